// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a single, already synchronized interrupt pin and turns its activity into an interrupt request. Software selects one of four sense modes: low level, any change, falling edge or rising edge. Software also sets an enable bit and can observe or clear a pending bit. These three values sit in byte-wide registers on a simple data bus. Writes take effect on the next clock edge, and reads are combinational on the address.

The pending bit is reported to the interrupt arbiter as a request whenever the enable bit is also set. The arbiter answers with a one-cycle acknowledge, which clears the pending bit in the change-driven modes. Low-level sensing works differently. There the pending bit follows the pin: while the pin stays low it cannot be cleared by a bus write or an acknowledge, and it drops only once the pin is seen high again. The vector word address of the request is presented as a constant beside it.

Edges are found by comparing each pin sample with the sample from the previous clock. That previous sample is held low after reset.

Top module: `extint_sense`

## Requirements
- R1: After reset the pending, enable and sense-select registers are zero, `irq_req` is 0 and every register reads as 0x00.
- R2: The pending bit is bit 0 at address 0x3C, the enable bit is bit 0 at address 0x3D, and the sense select is bits 1:0 at address 0x69. Unused bits and unmapped addresses read as zero. A write to 0x3D or 0x69 is visible on the following cycle.
- R3: With sense select 11 (rising), a low-to-high change between consecutive samples sets the pending bit one cycle later. A high-to-low change does not set it.
- R4: With sense select 10 (falling), a high-to-low change sets the pending bit. A low-to-high change does not set it.
- R5: With sense select 01 (any change), a change in either direction sets the pending bit.
- R6: With sense select 00 (low level), the pending bit is set while the pin is low and the enable bit is 1. It is cleared in the cycle after the pin is sampled high. Neither a write of 1 to bit 0 of 0x3C nor `irq_ack` clears it.
- R7: No event sets the pending bit while the enable bit is 0. `irq_req` is 1 exactly when both the pending and enable bits are 1.
- R8: In the three change-driven modes, writing 1 to bit 0 of 0x3C clears the pending bit. Writing 0 leaves it unchanged.
- R9: In the three change-driven modes, a cycle with `irq_ack` high clears the pending bit.
- R10: When a setting event coincides with a clear by write or acknowledge, the pending bit ends up set.
- R11: `irq_vec` always carries vector word address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_sync | input | 1 | Synchronized external pin level |
| irq_ack | input | 1 | Acknowledge pulse from the arbiter |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector word address of the request |

## Verification
The pin is driven with single rising and falling steps under each sense select, so that the two edge modes are seen to reject the opposite direction and any-change is seen to accept both. The low-level mode is tried with the pin held low across clear writes, acknowledges and an enable drop, which separates its sticky behaviour from the w1c/ack behaviour of the other modes. Steps that coincide with a write-one clear or an acknowledge show the priority of setting over clearing. A long stretch of random pin toggling, acknowledges and writes, including writes to unmapped addresses, is compared against the cycle model to catch orderings the directed steps miss.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic   enable;
        sense_e mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{enable: 1'b0, mode: SENSE_LOW};

    // event qualification between the current and previous pin samples
    function automatic logic sense_hit(sense_e mode, logic cur, logic prv);
        logic hit;
        unique case (mode)
            SENSE_LOW:  hit = ~cur;
            SENSE_ANY:  hit = cur ^ prv;
            SENSE_FALL: hit = prv & ~cur;
            SENSE_RISE: hit = cur & ~prv;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/extint_cfg_regs.sv
module extint_cfg_regs
    import extint_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h3D,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wr_en_bit,
    input  logic [1:0]        wr_mode,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            if (addr == EN_ADDR)   cfg.enable <= wr_en_bit;
            if (addr == MODE_ADDR) cfg.mode   <= sense_e'(wr_mode);
        end
    end

    // R2: written enable value is visible next cycle
    assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == EN_ADDR) |=> (cfg.enable == $past(wr_en_bit)));

endmodule

// File: rtl/extint_edge_detect.sv
module extint_edge_detect
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  sense_e mode,
    output logic   hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign hit = sense_hit(mode, pin, prev_q);

    // R3: a rising-mode hit only with the pin high
    assert_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_RISE && hit) |-> pin);

    // R4: a falling-mode hit only with the pin low
    assert_fall_level_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_FALL && hit) |-> !pin);

endmodule

// File: rtl/extint_pending.sv
module extint_pending
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e mode,
    input  logic   enable,
    input  logic   hit,
    input  logic   pin,
    input  logic   clr,
    output logic   pending
);

    logic level_mode;
    logic pend_d;

    assign level_mode = (mode == SENSE_LOW);

    always_comb begin
        pend_d = pending;
        if (level_mode) begin
            if (pin)         pend_d = 1'b0;
            else if (enable) pend_d = 1'b1;
        end else begin
            if (enable && hit) pend_d = 1'b1;
            else if (clr)      pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= pend_d;
    end

    // R6: sticky while the pin stays low
    assert_low_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (level_mode && pending && !pin) |=> pending);

    // R6: released once the pin is high
    assert_low_release_R6: assert property (@(posedge clk) disable iff (rst)
        (level_mode && pin) |=> !pending);

    // R7: nothing sets the bit with enable low
    assert_masked_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!pending && !enable) |=> !pending);

    // R8: clear in change-driven modes when no event competes
    assert_edge_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && clr && !(enable && hit)) |=> !pending);

    // R10: set beats clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && enable && hit) |=> pending);

endmodule

// File: rtl/extint_sense.sv
module extint_sense
    import extint_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                VEC_W     = 8,
    parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h3C,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h3D,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h69,
    parameter logic [VEC_W-1:0]  VECTOR    = 8'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_sync,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);

    localparam int MODE_W = $bits(sense_e);

    cfg_t cfg;
    logic hit;
    logic pending;
    logic w1c;

    extint_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .EN_ADDR   (EN_ADDR),
        .MODE_ADDR (MODE_ADDR)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wr_en_bit (bus_wdata[0]),
        .wr_mode   (bus_wdata[MODE_W-1:0]),
        .cfg       (cfg)
    );

    extint_edge_detect u_det (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin_sync),
        .mode (cfg.mode),
        .hit  (hit)
    );

    assign w1c = bus_we && (bus_addr == PEND_ADDR) && bus_wdata[0];

    extint_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg.mode),
        .enable  (cfg.enable),
        .hit     (hit),
        .pin     (pin_sync),
        .clr     (w1c | irq_ack),
        .pending (pending)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == PEND_ADDR)      bus_rdata[0] = pending;
        else if (bus_addr == EN_ADDR)   bus_rdata[0] = cfg.enable;
        else if (bus_addr == MODE_ADDR) bus_rdata[MODE_W-1:0] = cfg.mode;
    end

    assign irq_req = pending & cfg.enable;
    assign irq_vec = VECTOR;

    // R2: upper read bits stay zero
    assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:MODE_W] == '0);

    // R9: acknowledge clears in change-driven modes without a competing event
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && cfg.mode != SENSE_LOW && !(cfg.enable && hit)) |=> !irq_req);

endmodule

// File: tb/extint_sense_tb_top.sv
module extint_sense_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_PEND = 8'h3C;
    localparam logic [7:0] A_EN   = 8'h3D;
    localparam logic [7:0] A_MODE = 8'h69;

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic       bus_we = 0;
    logic [7:0] bus_rdata;
    logic       pin_sync = 0;
    logic       irq_ack = 0;
    logic       irq_req;
    logic [7:0] irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_pend = 0, m_en = 0, m_mode = 0, m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_sense dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_rd(logic [7:0] a);
        if (a == A_PEND) return m_pend;
        if (a == A_EN)   return m_en;
        if (a == A_MODE) return m_mode;
        return 0;
    endfunction

    always @(posedge clk) begin
        int p, ev, np;
        if (rst) begin
            m_pend = 0; m_en = 0; m_mode = 0; m_prev = 0;
        end else begin
            p  = int'(pin_sync);
            ev = 0;
            if (m_mode == 1 && p != m_prev) ev = 1;
            if (m_mode == 2 && m_prev == 1 && p == 0) ev = 1;
            if (m_mode == 3 && m_prev == 0 && p == 1) ev = 1;
            np = m_pend;
            if (m_mode == 0) begin
                if (p == 1) np = 0;
                else if (m_en == 1) np = 1;
            end else if (m_en == 1 && ev == 1) np = 1;
            else if (irq_ack || (bus_we && bus_addr == A_PEND && bus_wdata[0])) np = 0;
            if (bus_we && bus_addr == A_EN)   m_en = int'(bus_wdata[0]);
            if (bus_we && bus_addr == A_MODE) m_mode = int'(bus_wdata[1:0]);
            m_prev = p;
            m_pend = np;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("model rdata R2", int'(bus_rdata), model_rd(bus_addr));
            check("model irq_req R7", int'(irq_req), (m_pend == 1 && m_en == 1) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        tick();
        bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, int exp, string tag);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic pin_step(logic v);
        pin_sync = v;
        tick();
    endtask

    task automatic ack_pulse();
        irq_ack = 1;
        tick();
        irq_ack = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        rd(A_PEND, 0, "R1 pending");
        rd(A_EN, 0, "R1 enable");
        rd(A_MODE, 0, "R1 mode");
        check("R1 irq_req", int'(irq_req), 0);
        check("R11 vector", int'(irq_vec), 2);
        rst = 0;
        pin_step(1);

        // R2 register access
        wr(A_MODE, 8'hFE);
        rd(A_MODE, 2, "R2 mode read");
        wr(A_EN, 8'hFF);
        rd(A_EN, 1, "R2 enable read");
        rd(8'h50, 0, "R2 unmapped");
        rd(A_PEND, 0, "R2 pending idle");

        // R4 falling
        pin_step(0);
        rd(A_PEND, 1, "R4 falling sets");
        check("R7 req with enable", int'(irq_req), 1);
        wr(A_PEND, 8'h00);
        rd(A_PEND, 1, "R8 write zero keeps");
        wr(A_PEND, 8'h01);
        rd(A_PEND, 0, "R8 write one clears");
        pin_step(1);
        rd(A_PEND, 0, "R4 rising ignored");

        // R3 rising
        wr(A_MODE, 8'h03);
        pin_step(0);
        rd(A_PEND, 0, "R3 falling ignored");
        pin_step(1);
        rd(A_PEND, 1, "R3 rising sets");
        ack_pulse();
        rd(A_PEND, 0, "R9 ack clears");

        // R5 any change
        wr(A_MODE, 8'h01);
        pin_step(0);
        rd(A_PEND, 1, "R5 fall sets");
        wr(A_PEND, 8'h01);
        pin_step(1);
        rd(A_PEND, 1, "R5 rise sets");
        ack_pulse();
        rd(A_PEND, 0, "R9 ack clears any");

        // R7 enable gating
        wr(A_EN, 8'h00);
        pin_step(0);
        rd(A_PEND, 0, "R7 masked event");
        check("R7 req masked", int'(irq_req), 0);
        wr(A_EN, 8'h01);
        pin_step(1);
        rd(A_PEND, 1, "R7 enabled event");
        wr(A_EN, 8'h00);
        rd(A_PEND, 1, "R7 pending kept");
        check("R7 req dropped", int'(irq_req), 0);
        wr(A_PEND, 8'h01);
        wr(A_EN, 8'h01);

        // R10 set wins (pin high, any mode)
        pin_sync = 0; irq_ack = 1;
        tick();
        irq_ack = 0;
        rd(A_PEND, 1, "R10 set over ack");
        wr(A_PEND, 8'h01);
        rd(A_PEND, 0, "R8 clear before race");
        bus_addr = A_PEND; bus_wdata = 8'h01; bus_we = 1; pin_sync = 1;
        tick();
        bus_we = 0;
        rd(A_PEND, 1, "R10 set over write");
        wr(A_PEND, 8'h01);

        // R6 low level (pin high now)
        wr(A_MODE, 8'h00);
        pin_step(0);
        rd(A_PEND, 1, "R6 low sets");
        wr(A_PEND, 8'h01);
        rd(A_PEND, 1, "R6 write ignored");
        ack_pulse();
        rd(A_PEND, 1, "R6 ack ignored");
        wr(A_EN, 8'h00);
        rd(A_PEND, 1, "R6 held with enable off");
        check("R6 req gated", int'(irq_req), 0);
        pin_step(1);
        rd(A_PEND, 0, "R6 pin high releases");
        wr(A_EN, 8'h01);
        pin_step(0);
        rd(A_PEND, 1, "R6 low again");

        // random phase compared by the model each cycle
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom % 16;
            pin_sync = ($urandom % 3) == 0 ? ~pin_sync : pin_sync;
            irq_ack  = (r == 0);
            bus_we   = (r >= 12);
            case ($urandom % 4)
                0: bus_addr = A_PEND;
                1: bus_addr = A_EN;
                2: bus_addr = A_MODE;
                default: bus_addr = 8'h40;
            endcase
            bus_wdata = 8'($urandom);
            tick();
        end
        bus_we = 0; irq_ack = 0;
        tick();
        finish_run();
    end

endmodule